// File: doc/BRIEF.md
# Card Clock Divider with Glitch-Free Ratio Switching

This block derives the clock sent to a smart card from a reference clock. Two select inputs choose a ratio of 1, 2, 4 or 8. A gate input from the activation sequencer starts and stops the card clock. The output never carries a truncated high or low phase, either when the ratio changes or when the gate changes. Whenever the gate is off or the block is in reset, the card clock rests low.

A free-running counter, three bits wide by default, counts reference rising edges. Its bits supply the divided clocks, and a registered output stage drives them out at a 50 % duty cycle. Ratio 1 passes the reference through a clock-gating latch whose enable changes only while the reference is low. The select and gate inputs are sampled together on one edge only: the edge where the counter wraps to zero. At that edge every divided phase is ending a high phase and starting a low phase. A setting change therefore always falls on a common boundary of the old and new clocks.

Top module: `cardclk_div`

## Requirements
- R1: While reset is asserted, `card_clk` is low, and the counter restarts from zero when reset is released.
- R2: With the gate on, the select value picks the ratio as follows: 2'b00 gives reference/8, 2'b01 gives reference/4, 2'b11 gives reference/2 and 2'b10 gives reference/1. For ratio N>1, `card_clk` is high for N/2 reference periods and low for N/2 periods, and it is high exactly when bit log2(N)-1 of the counter is set.
- R3: In ratio 1 with the gate on, `card_clk` is high during the reference high phase and low during the reference low phase.
- R4: `ratio_sel` and `clk_gate` are sampled only on the reference rising edge at which the counter wraps to zero. This is every 8th edge after reset release. A change at any other time has no effect on `card_clk` until that edge.
- R5: When one divided ratio changes to another divided ratio, the last high phase of the old ratio is complete, and the new ratio starts with a complete low phase at the wrap edge.
- R6: When the gate is sampled off, `card_clk` stays low from the wrap edge on, and the last pulse before it is complete.
- R7: When the gate is sampled on, the first pulse comes after a complete low phase of the selected ratio.
- R8: On entry to ratio 1, the reference cycle that starts at the wrap edge stays low, and pulses begin on the next rising edge. On exit from ratio 1, that same cycle still carries one complete ratio-1 high phase. After it, the output is low until the new ratio's first high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio_sel | input | 2 | Ratio select code |
| clk_gate | input | 1 | Card clock enable from the sequencer |
| card_clk | output | 1 | Clock to the card |

## Verification
A ratio change and a gate change can be sampled on the same wrap edge. The bench provokes this by toggling `clk_gate` and `ratio_sel` in the same half cycle, from every select value and into every select value. It also flips the select for one cycle in the middle of a frame, to show that such a change is ignored. The bench judges each case half-period by half-period against an arithmetic model. In that model, the output level during the high half of a cycle depends on the ratio-1 enable of the previous cycle. The divided level depends on the counter value and the setting that applies now.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
package cdiv_pkg;

  // Counter width; the largest ratio is 2**CNT_W.
  localparam int CNT_W = 3;

  // Order matters: value v>0 selects counter bit v-1.
  typedef enum logic [1:0] {
    RATIO_1 = 2'd0,
    RATIO_2 = 2'd1,
    RATIO_4 = 2'd2,
    RATIO_8 = 2'd3
  } ratio_e;

  // Non-binary select table.
  function automatic ratio_e decode_sel(input logic [1:0] code);
    case (code)
      2'b00:   decode_sel = RATIO_8;
      2'b01:   decode_sel = RATIO_4;
      2'b11:   decode_sel = RATIO_2;
      default: decode_sel = RATIO_1;
    endcase
  endfunction

  // Level of a divided clock for a given counter value.
  function automatic logic phase_bit(input ratio_e r, input logic [CNT_W-1:0] c);
    logic [1:0] idx;
    idx = 2'(r) - 2'd1;
    if (r == RATIO_1) phase_bit = 1'b0;
    else              phase_bit = c[idx];
  endfunction

endpackage

// File: rtl/cdiv_counter.sv
`timescale 1ns/1ps
module cdiv_counter #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt,
  output logic         wrap_nxt
);
  localparam logic [W-1:0] LAST = {W{1'b1}};

  assign cnt_nxt  = cnt + 1'b1;
  assign wrap_nxt = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/cdiv_ctrl.sv
`timescale 1ns/1ps
module cdiv_ctrl
  import cdiv_pkg::*;
#(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wrap_nxt,
  input  logic [W-1:0] cnt_nxt,
  input  logic [1:0]   sel,
  input  logic         gate,
  output ratio_e       mode,
  output logic         run,
  output logic         div_q
);
  ratio_e mode_nxt;
  logic   run_nxt;

  // Settings advance only on the wrap edge (common low boundary).
  assign mode_nxt = wrap_nxt ? decode_sel(sel) : mode;
  assign run_nxt  = wrap_nxt ? gate : run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= RATIO_8;
      run   <= 1'b0;
      div_q <= 1'b0;
    end else begin
      mode  <= mode_nxt;
      run   <= run_nxt;
      div_q <= run_nxt && (mode_nxt != RATIO_1) && phase_bit(mode_nxt, cnt_nxt);
    end
  end
endmodule

// File: rtl/cdiv_fast_gate.sv
`timescale 1ns/1ps
module cdiv_fast_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic gclk
);
  logic en_lat;

  // Enable passes only while the clock is low, so a high phase is never cut.
  always_latch begin
    if (!rst_n)    en_lat = 1'b0;
    else if (!clk) en_lat = en;
  end

  assign gclk = clk & en_lat;
endmodule

// File: rtl/cardclk_div.sv
`timescale 1ns/1ps
module cardclk_div
  import cdiv_pkg::*;
#(
  parameter int CNT_W_P = cdiv_pkg::CNT_W
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic [1:0] ratio_sel,
  input  logic       clk_gate,
  output logic       card_clk
);
  logic [CNT_W_P-1:0] cnt_q;
  logic [CNT_W_P-1:0] cnt_nxt;
  logic               wrap_nxt;
  ratio_e             mode_q;
  logic               run_q;
  logic               div_q;
  logic               fast_en;
  logic               fast_clk;

  cdiv_counter #(.W(CNT_W_P)) u_cnt (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .cnt      (cnt_q),
    .cnt_nxt  (cnt_nxt),
    .wrap_nxt (wrap_nxt)
  );

  cdiv_ctrl #(.W(CNT_W_P)) u_ctrl (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .wrap_nxt (wrap_nxt),
    .cnt_nxt  (cnt_nxt),
    .sel      (ratio_sel),
    .gate     (clk_gate),
    .mode     (mode_q),
    .run      (run_q),
    .div_q    (div_q)
  );

  assign fast_en = run_q && (mode_q == RATIO_1);

  cdiv_fast_gate u_fast (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .en    (fast_en),
    .gclk  (fast_clk)
  );

  // The two sources are never high together.
  assign card_clk = fast_clk | div_q;
endmodule

// File: rtl/cardclk_div_chk.sv
`timescale 1ns/1ps
module cardclk_div_chk #(
  parameter int CW = 3
) (
  input logic          clk_ref,
  input logic          rst_n,
  input logic [CW-1:0] cnt,
  input logic [1:0]    mode,
  input logic          run,
  input logic          div_q
);
  AST_CNT_STEP: assert property (@(posedge clk_ref) disable iff (!rst_n)
    rst_n |=> (cnt == CW'($past(cnt) + 1'b1)));                                  // R1
  AST_DIV2_TOGGLE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (run && mode == 2'd1 && cnt != '0) |-> (div_q != $past(div_q)));               // R2
  AST_FAST_NO_DIV: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (mode == 2'd0) |-> !div_q);                                                    // R3
  AST_SETTING_AT_WRAP: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (cnt != '0) |-> ($stable(mode) && $stable(run)));                              // R4
  AST_DIV_LOW_AT_WRAP: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (cnt == '0) |-> !div_q);                                                       // R5
  AST_STOPPED_LOW: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !run |-> !div_q);                                                              // R6
endmodule

bind cardclk_div cardclk_div_chk #(.CW(CNT_W_P)) u_chk (
  .clk_ref (clk_ref),
  .rst_n   (rst_n),
  .cnt     (cnt_q),
  .mode    (mode_q),
  .run     (run_q),
  .div_q   (div_q)
);

// File: tb/sim_cardclk_div.sv
`timescale 1ns/1ps
module sim_cardclk_div;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       gate = 1'b0;
  logic       card_clk;

  int nchk = 0;
  int nfail = 0;
  int k = 0;
  int cur_r = 8, cur_run = 0, prv_r = 8, prv_run = 0;

  always #5 clk = ~clk;

  cardclk_div u0 (
    .clk_ref   (clk),
    .rst_n     (rst_n),
    .ratio_sel (sel),
    .clk_gate  (gate),
    .card_clk  (card_clk)
  );

  // R2 table restated: 00->8, 01->4, 11->2, 10->1
  function automatic int ratio_of(input logic [1:0] s);
    case (s)
      2'b00:   return 8;
      2'b01:   return 4;
      2'b11:   return 2;
      default: return 1;
    endcase
  endfunction

  function automatic logic div_lvl(input int r, input int v);
    if (r < 2) return 1'b0;
    return (((v % 8) / (r / 2)) % 2) == 1;
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s k=%0d r=%0d run=%0d actual=%b expected=%b", tag, k, cur_r, cur_run, act, exp);
    end
  endtask

  task automatic tick();
    string tag;
    logic  e;
    logic  pend;
    @(posedge clk); #2;
    prv_r = cur_r; prv_run = cur_run;
    pend = (ratio_of(sel) != cur_r) || (gate != cur_run);
    k++;
    if (k % 8 == 0) begin
      cur_r = ratio_of(sel);
      cur_run = gate;
    end
    if (prv_run != cur_run)             tag = cur_run ? "R7" : "R6";
    else if (prv_r != cur_r && cur_run) tag = (prv_r == 1 || cur_r == 1) ? "R8" : "R5";
    else if (pend)                      tag = "R4";
    else if (!cur_run)                  tag = "R6";
    else if (cur_r == 1)                tag = "R3";
    else                                tag = "R2";
    e = (prv_run && prv_r == 1) || (cur_run && div_lvl(cur_r, k));
    chk(card_clk, e, tag);
    @(negedge clk); #2;
    e = cur_run && div_lvl(cur_r, k);
    chk(card_clk, e, tag);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_reset();
    @(negedge clk); #2;
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #2; chk(card_clk, 1'b0, "R1");
      @(negedge clk); #2; chk(card_clk, 1'b0, "R1");
    end
    rst_n = 1'b1;
    k = 0; cur_r = 8; cur_run = 0; prv_r = 8; prv_run = 0;
  endtask

  initial begin
    #1_500_000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    do_reset();
    cycles(10);                       // gate still off: R6
    gate = 1'b1; sel = 2'b00;         // R7 start in /8
    cycles(24);
    for (int o = 0; o < 4; o++) begin
      for (int n = 0; n < 4; n++) begin
        sel = 2'(o);
        cycles(16);
        sel = 2'(n);                  // R5 / R8 transitions
        cycles(3);
        sel = 2'(n) ^ 2'b01;          // short flip inside a frame: R4
        cycles(1);
        sel = 2'(n);
        cycles(20);
      end
    end
    for (int s = 0; s < 4; s++) begin
      gate = 1'b0; sel = 2'(s);       // stop and change together
      cycles(17);
      gate = 1'b1; sel = 2'(3 - s);   // start and change together
      cycles(17);
      gate = 1'b0;
      cycles(3);
      gate = 1'b1;                    // brief drop mid-frame: R4
      cycles(13);
    end
    sel = 2'b10;
    cycles(12);
    do_reset();                       // reset while running in ratio 1
    cycles(20);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule